// File: doc/BRIEF.md
# Polyphase Programmable Transmit Equalizer

This block sits in front of a four-way interleaved digital-to-analog converter and pre-distorts the transmit stream. On every clock it takes one frame of four input symbols and returns four equalized samples, one for each converter phase. Each phase holds its own five-tap coefficient set for each of two input branches. The same hardware therefore acts as a plain time-invariant FIR, as a cyclic time-variant equalizer that can correct mismatch between the interleaved converter paths, or as a two-lane 8-PAM combiner that adds a 4-PAM branch and a 2-PAM branch.

A 2-bit mode input selects the operating mode. Coefficients are loaded one at a time through an address/data/write-enable port. Sums keep full precision until a final round-and-saturate stage. Branch 0 is the 4-PAM branch and branch 1 is the 2-PAM branch. Setting a tap pattern such as equal weights at tap 0 and tap 3 adds a delayed copy of the stream onto itself, which gives a stress pattern.

Top module: `ptx_equalizer`

## Requirements
- R1: After reset, sampleOut is all zero, and every coefficient and every history entry is zero.
- R2: coefAddr is laid out as {phase[5:4], branch[3], tap[2:0]}. Tap 0 weights the current sample and tap t weights the sample t positions older.
- R3: 4-PAM symbols use Gray-coded levels 00→−3, 01→−1, 11→+1 and 10→+3. Lane k of symIn is bits [2k+1:2k], and lane 0 is the oldest sample in the frame.
- R4: Lane k of sampleOut (bits [10k+9:10k]) is the rounded value of Σ over branch and tap of coef×sample. Older taps reach back across frame boundaries into earlier frames. The result appears one clock after the frame is presented.
- R5: A coefficient write takes effect from the frame presented in the following cycle. The frame presented in the same cycle as the write still uses the old value.
- R6: A write whose tap field is 5, 6 or 7 changes nothing.
- R7: Mode 0 (time-invariant) applies the phase-0 sets to every lane. Mode 1 with four identical phase sets gives the same output as mode 0.
- R8: Mode 1 (cyclic) applies the phase-k sets to lane k.
- R9: Mode 3 (2-PAM cyclic) maps bit 2k to +1 when it is 1 and to −1 when it is 0. This feeds branch 1 of lane k, and branch 0 carries zero.
- R10: Mode 2 (8-PAM) carries two symbols per frame. Symbol j takes a 4-PAM value from field 2j (branch 0) and a 2-PAM value from bit 0 of field 2j+1 (branch 1), and uses the phase-j sets. Its result is driven on both lanes 2j and 2j+1. When the branch-0 taps are twice the branch-1 taps, the result is the equalized 8-PAM level ±1, ±3, ±5, ±7.
- R11: Each output is (sum + 2) >>> 2, clamped to the range −511…+511.
- R12: In the frame where modeIn differs from the previous frame's mode, every history sample reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeIn | input | 2 | Operating mode: 0 time-invariant, 1 cyclic, 2 8-PAM, 3 2-PAM cyclic |
| symIn | input | 8 | Four 2-bit symbol fields, one frame per clock |
| coefWe | input | 1 | Coefficient write strobe |
| coefAddr | input | 6 | Phase, branch and tap of the coefficient to write |
| coefData | input | 8 | Signed coefficient value |
| sampleOut | output | 40 | Four signed 10-bit equalized samples, lane 0 in the low bits |

## Verification
A corrupted history register shows up only as a wrong older-tap contribution. It appears on the lanes whose taps reach that entry within one to two frames and then clears once the entry shifts out. The bench therefore runs long multi-tap patterns and compares every lane of every frame. A wrong phase-select or coefficient entry is visible in the first frame that exercises that lane with a nonzero tap, so each phase set is loaded with distinct values. A mode register that fails to clear leaves stale history in the first frame after a switch, so mode changes are interleaved with checked traffic.

// File: rtl/ptxeq_pkg.sv
package ptxeq_pkg;

  localparam int BRANCHES = 2;

  typedef enum logic [1:0] {
    MODE_LTI  = 2'd0,
    MODE_CTV  = 2'd1,
    MODE_PAM8 = 2'd2,
    MODE_PAM2 = 2'd3
  } eqMode_t;

  typedef struct packed {
    logic    clearHist;
    logic    coefWe;
    eqMode_t mode;
  } ctrlStrobe_t;

  function automatic logic signed [3:0] grayLevel(input logic [1:0] g);
    case (g)
      2'b00:   return -4'sd3;
      2'b01:   return -4'sd1;
      2'b11:   return 4'sd1;
      default: return 4'sd3;
    endcase
  endfunction

  function automatic logic signed [3:0] binLevel(input logic b);
    return b ? 4'sd1 : -4'sd1;
  endfunction

endpackage

// File: rtl/ptxeq_ctrl.sv
module ptxeq_ctrl
  import ptxeq_pkg::*;
#(
  parameter int TAPS = 5,
  parameter int TW   = 3,
  parameter int AW   = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    modeIn,
  input  logic          coefWe,
  input  logic [AW-1:0] coefAddr,
  output ctrlStrobe_t   strobe
);

  eqMode_t modeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeReg <= MODE_LTI;
    else       modeReg <= eqMode_t'(modeIn);
  end

  always_comb begin
    strobe.mode      = eqMode_t'(modeIn);
    strobe.clearHist = (eqMode_t'(modeIn) != modeReg);
    strobe.coefWe    = coefWe && (int'(coefAddr[TW-1:0]) < TAPS);
  end

endmodule

// File: rtl/ptxeq_datapath.sv
module ptxeq_datapath
  import ptxeq_pkg::*;
#(
  parameter int LANES = 4,
  parameter int TAPS  = 5,
  parameter int CW    = 8,
  parameter int OW    = 10,
  parameter int SHIFT = 2,
  parameter int PW    = 2,
  parameter int TW    = 3,
  parameter int AW    = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strobe,
  input  logic [2*LANES-1:0]     symIn,
  input  logic [AW-1:0]          coefAddr,
  input  logic signed [CW-1:0]   coefData,
  output logic [OW*LANES-1:0]    sampleOut
);

  localparam int HL   = TAPS - 1;
  localparam int AccW = CW + 4 + $clog2(BRANCHES * TAPS) + 1;
  localparam logic signed [AccW-1:0] OutMax     = AccW'((1 <<< (OW - 1)) - 1);
  localparam logic signed [AccW-1:0] RoundBias  = AccW'(1 <<< (SHIFT - 1));

  logic signed [CW-1:0]   coef     [LANES][BRANCHES][TAPS];
  logic signed [3:0]      hist     [BRANCHES][HL];
  logic signed [3:0]      histEff  [BRANCHES][HL];
  logic signed [3:0]      histNext [BRANCHES][HL];
  logic signed [3:0]      cur      [BRANCHES][LANES];
  logic signed [AccW-1:0] acc      [LANES];
  logic signed [AccW-1:0] shf      [LANES];
  logic [OW-1:0]          laneVal  [LANES];
  logic [OW*LANES-1:0]    outNext;
  int                     frameLen;

  // symbol decode per mode
  always_comb begin
    frameLen = (strobe.mode == MODE_PAM8) ? LANES / 2 : LANES;
    for (int b = 0; b < BRANCHES; b++)
      for (int k = 0; k < LANES; k++) cur[b][k] = '0;
    for (int k = 0; k < LANES; k++) begin
      case (strobe.mode)
        MODE_PAM2: cur[1][k] = binLevel(symIn[2*k]);
        MODE_PAM8: if (k < LANES / 2) begin
          cur[0][k] = grayLevel(symIn[(4*k) % (2*LANES) +: 2]);
          cur[1][k] = binLevel(symIn[(4*k+2) % (2*LANES)]);
        end
        default:   cur[0][k] = grayLevel(symIn[2*k +: 2]);
      endcase
    end
  end

  // history view and update
  always_comb begin
    for (int b = 0; b < BRANCHES; b++) begin
      for (int i = 0; i < HL; i++)
        histEff[b][i] = strobe.clearHist ? 4'sd0 : hist[b][i];
      for (int i = 0; i < HL; i++) begin
        if (i < frameLen) histNext[b][i] = cur[b][frameLen-1-i];
        else              histNext[b][i] = histEff[b][i-frameLen];
      end
    end
  end

  // polyphase multiply-accumulate with round and clamp
  always_comb begin
    outNext = '0;
    for (int k = 0; k < LANES; k++) begin
      int ph;
      ph = (strobe.mode == MODE_LTI) ? 0 : k;
      acc[k] = '0;
      for (int b = 0; b < BRANCHES; b++) begin
        for (int t = 0; t < TAPS; t++) begin
          logic signed [3:0] smp;
          if (k - t >= 0) smp = cur[b][k-t];
          else            smp = histEff[b][t-k-1];
          acc[k] = acc[k] + AccW'(coef[ph][b][t]) * AccW'(smp);
        end
      end
      shf[k] = (acc[k] + RoundBias) >>> SHIFT;
      if (shf[k] > OutMax)       laneVal[k] = OutMax[OW-1:0];
      else if (shf[k] < -OutMax) laneVal[k] = (-OutMax) >>> 0 == '0 ? '0 : OW'(-OutMax);
      else                       laneVal[k] = shf[k][OW-1:0];
    end
    for (int k = 0; k < LANES; k++)
      outNext[k*OW +: OW] = (strobe.mode == MODE_PAM8) ? laneVal[k/2] : laneVal[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coef      <= '{default: '0};
      hist      <= '{default: '0};
      sampleOut <= '0;
    end else begin
      if (strobe.coefWe)
        coef[coefAddr[AW-1 -: PW]][coefAddr[TW]][coefAddr[TW-1:0]] <= coefData;
      hist      <= histNext;
      sampleOut <= outNext;
    end
  end

endmodule

// File: rtl/ptx_equalizer.sv
module ptx_equalizer
  import ptxeq_pkg::*;
#(
  parameter int LANES = 4,
  parameter int TAPS  = 5,
  parameter int CW    = 8,
  parameter int OW    = 10,
  parameter int SHIFT = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [1:0]                 modeIn,
  input  logic [2*LANES-1:0]         symIn,
  input  logic                       coefWe,
  input  logic [$clog2(LANES)+1+$clog2(TAPS)-1:0] coefAddr,
  input  logic [CW-1:0]              coefData,
  output logic [OW*LANES-1:0]        sampleOut
);

  localparam int PW = $clog2(LANES);
  localparam int TW = $clog2(TAPS);
  localparam int AW = PW + 1 + TW;

  ctrlStrobe_t strobe;

  ptxeq_ctrl #(.TAPS(TAPS), .TW(TW), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeIn(modeIn),
    .coefWe(coefWe), .coefAddr(coefAddr), .strobe(strobe)
  );

  ptxeq_datapath #(
    .LANES(LANES), .TAPS(TAPS), .CW(CW), .OW(OW), .SHIFT(SHIFT),
    .PW(PW), .TW(TW), .AW(AW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .symIn(symIn),
    .coefAddr(coefAddr), .coefData(coefData), .sampleOut(sampleOut)
  );

endmodule

// File: rtl/ptx_equalizer_chk.sv
module ptx_equalizer_chk #(
  parameter int LANES = 4,
  parameter int OW    = 10
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [1:0]             modeIn,
  input logic [2*LANES-1:0]     symIn,
  input logic [OW*LANES-1:0]    sampleOut
);

  localparam logic [OW-1:0] MinCode = {1'b1, {(OW-1){1'b0}}};

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> sampleOut == '0); // R1

  AST_LTI_FLAT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && modeIn == 2'd0 && $past(modeIn) == 2'd0 &&
     symIn == $past(symIn) && symIn == {LANES{symIn[1:0]}})
    |=> sampleOut == {LANES{sampleOut[OW-1:0]}}); // R7

  for (genvar j = 0; j < LANES / 2; j++) begin : g_pair
    AST_PAIRED_LANES: assert property (@(posedge clk) disable iff (!rstN)
      modeIn == 2'd2 |=> sampleOut[2*j*OW +: OW] == sampleOut[(2*j+1)*OW +: OW]); // R10
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    AST_NO_MIN_CODE: assert property (@(posedge clk) disable iff (!rstN)
      sampleOut[k*OW +: OW] != MinCode); // R11
  end

endmodule

bind ptx_equalizer ptx_equalizer_chk #(.LANES(LANES), .OW(OW)) u_chk (
  .clk(clk), .rstN(rstN), .modeIn(modeIn), .symIn(symIn), .sampleOut(sampleOut)
);

// File: tb/sim_ptx_equalizer.sv
module sim_ptx_equalizer;
  localparam int LANES = 4;
  localparam int TAPS  = 5;
  localparam int OW    = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  modeIn = '0;
  logic [7:0]  symIn = '0;
  logic        coefWe = 1'b0;
  logic [5:0]  coefAddr = '0;
  logic [7:0]  coefData = '0;
  logic [39:0] sampleOut;

  always #4 clk = ~clk;

  ptx_equalizer u0 (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .symIn(symIn),
    .coefWe(coefWe), .coefAddr(coefAddr), .coefData(coefData), .sampleOut(sampleOut)
  );

  typedef struct { logic [39:0] exp; string tag; } item_t;
  item_t q[$];
  int nChecks = 0, nFail = 0;
  int mc[LANES][2][TAPS];
  int s0[$], s1[$];
  int prevMode = 0;
  logic [15:0] lf = 16'hACE1;
  bit finished = 0;

  function automatic int lvl4(input logic [1:0] g);
    case (g) 2'b00: return -3; 2'b01: return -1; 2'b11: return 1; default: return 3; endcase
  endfunction

  function automatic int roundSat(input int a);
    int r;
    r = (a + 2) >>> 2;
    if (r > 511) r = 511;
    if (r < -511) r = -511;
    return r;
  endfunction

  function logic [7:0] nextSym();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[7:0];
  endfunction

  task automatic step(input logic [7:0] sym, input logic [1:0] m, input string tag,
                      input bit we = 0, input logic [5:0] addr = '0, input int data = 0);
    int L, n, ph, acc;
    int res[4];
    logic [39:0] e;
    @(negedge clk);
    symIn = sym; modeIn = m; coefWe = we; coefAddr = addr; coefData = 8'(data);
    if (int'(m) != prevMode) begin s0.delete(); s1.delete(); end   // R12
    prevMode = int'(m);
    L = (m == 2'd2) ? 2 : 4;
    for (int i = 0; i < L; i++) begin
      case (m)
        2'd3: begin s0.push_back(0); s1.push_back(sym[2*i] ? 1 : -1); end
        2'd2: begin s0.push_back(lvl4(sym[4*i +: 2])); s1.push_back(sym[4*i+2] ? 1 : -1); end
        default: begin s0.push_back(lvl4(sym[2*i +: 2])); s1.push_back(0); end
      endcase
    end
    for (int i = 0; i < L; i++) begin
      n = s0.size() - L + i;
      ph = (m == 2'd0) ? 0 : (m == 2'd2) ? n % 2 : n % 4;
      acc = 0;
      for (int t = 0; t < TAPS; t++)
        if (n - t >= 0) acc += mc[ph][0][t] * s0[n-t] + mc[ph][1][t] * s1[n-t];
      res[i] = roundSat(acc);
    end
    for (int k = 0; k < 4; k++)
      e[k*OW +: OW] = OW'((m == 2'd2) ? res[k/2] : res[k]);
    q.push_back('{e, tag});
    if (we && addr[2:0] < 3'd5) mc[addr[5:4]][addr[3]][addr[2:0]] = data;
  endtask

  task automatic loadSet(input int ph, input int br, input int c[5], input logic [1:0] m, input string tag);
    for (int t = 0; t < TAPS; t++)
      step(nextSym(), m, tag, 1'b1, {2'(ph), 1'(br), 3'(t)}, c[t]);
  endtask

  task automatic run(input int cnt, input logic [1:0] m, input string tag);
    for (int i = 0; i < cnt; i++) step(nextSym(), m, tag);
  endtask

  // monitor / scoreboard
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        nChecks++;
        if (sampleOut !== it.exp) begin
          nFail++;
          $display("FAIL %s: got %h expected %h", it.tag, sampleOut, it.exp);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < LANES; p++)
      for (int b = 0; b < 2; b++)
        for (int t = 0; t < TAPS; t++) mc[p][b][t] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    nChecks++;
    if (sampleOut !== '0) begin
      nFail++;
      $display("FAIL R1 reset: got %h expected 0", sampleOut);
    end
    rstN = 1'b1;
    run(3, 2'd0, "R1 zero coefficients");

    // R2/R3: unit tap 0 reproduces the Gray levels
    loadSet(0, 0, '{4, 0, 0, 0, 0}, 2'd0, "R2 load");
    step(8'hB4, 2'd0, "R3 all four codes");
    step(8'h00, 2'd0, "R3 all 00");
    step(8'hFF, 2'd0, "R3 all 11");
    step(8'hAA, 2'd0, "R3 all 10");
    run(6, 2'd0, "R3 random");

    // R4: multi-tap, history across frames
    loadSet(0, 0, '{8, -4, 2, 1, -3}, 2'd0, "R4 load");
    run(16, 2'd0, "R4 cross-frame taps");
    loadSet(0, 0, '{4, 0, 0, 4, 0}, 2'd0, "R4 delayed self-add");
    run(8, 2'd0, "R4 delayed self-add");

    // R5: write lands on next frame
    step(nextSym(), 2'd0, "R5 write cycle", 1'b1, 6'b00_0_000, 20);
    run(2, 2'd0, "R5 after write");

    // R6: tap fields 5..7 ignored
    step(nextSym(), 2'd0, "R6 tap5", 1'b1, 6'b00_0_101, 127);
    step(nextSym(), 2'd0, "R6 tap6", 1'b1, 6'b01_1_110, -128);
    step(nextSym(), 2'd0, "R6 tap7", 1'b1, 6'b11_0_111, 99);
    run(4, 2'd0, "R6 unchanged");
    step(8'h55, 2'd0, "R7 flat"); step(8'h55, 2'd0, "R7 flat");

    // R7: identical phase sets in mode 1
    loadSet(0, 0, '{12, -5, 3, 0, 1}, 2'd0, "R7 load");
    for (int p = 1; p < 4; p++) loadSet(p, 0, '{12, -5, 3, 0, 1}, 2'd0, "R7 load");
    run(8, 2'd0, "R7 mode 0");
    run(8, 2'd1, "R7 mode 1 identical");

    // R8: distinct phase sets
    loadSet(1, 0, '{-7, 9, 0, 2, -1}, 2'd1, "R8 load");
    loadSet(2, 0, '{30, 0, -8, 4, 0}, 2'd1, "R8 load");
    loadSet(3, 0, '{1, 1, 1, 1, 1}, 2'd1, "R8 load");
    run(16, 2'd1, "R8 cyclic");

    // R9: 2-PAM on branch 1
    for (int p = 0; p < 4; p++) loadSet(p, 1, '{16 + p, -6, 3 * p, 0, -2}, 2'd3, "R9 load");
    run(16, 2'd3, "R9 2-PAM");

    // R10: 8-PAM combining, branch 0 doubled
    loadSet(0, 1, '{10, -3, 2, 0, 1}, 2'd2, "R10 load");
    loadSet(0, 0, '{20, -6, 4, 0, 2}, 2'd2, "R10 load");
    loadSet(1, 1, '{8, 2, -1, 1, 0}, 2'd2, "R10 load");
    loadSet(1, 0, '{16, 4, -2, 2, 0}, 2'd2, "R10 load");
    run(16, 2'd2, "R10 8-PAM");

    // R11: saturation at both rails and rounding
    for (int p = 0; p < 2; p++) begin
      loadSet(p, 0, '{127, 127, 127, 127, 127}, 2'd2, "R11 load");
      loadSet(p, 1, '{127, 127, 127, 127, 127}, 2'd2, "R11 load");
    end
    for (int i = 0; i < 4; i++) step(8'hEE, 2'd2, "R11 positive rail");
    for (int i = 0; i < 4; i++) step(8'h00, 2'd2, "R11 negative rail");
    loadSet(0, 0, '{1, 0, 0, 0, 0}, 2'd0, "R11 load");
    step(8'hB4, 2'd0, "R11 rounding");
    step(8'h00, 2'd0, "R11 rounding");

    // R12: mode changes clear history
    loadSet(0, 0, '{9, 7, -5, 3, 6}, 2'd0, "R12 load");
    for (int i = 0; i < 6; i++) begin
      run(2, 2'd0, "R12 switch");
      run(2, 2'd1, "R12 switch");
      run(1, 2'd2, "R12 switch");
      run(1, 2'd3, "R12 switch");
    end

    @(negedge clk);
    coefWe = 1'b0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule